// File: doc/BRIEF.md
# Read/Write Turnaround Direction Arbiter

This block chooses whether a memory controller's shared data bus is given to reads or to writes. It watches how full the read queue and the write queue are, counts the read and write bursts issued since the bus last changed direction, and listens to a stall flag from the write path. From these inputs it drives a registered direction bit and a one-cycle pulse in the cycle the direction changes. The command scheduler reads the direction to pick which queue to serve.

Every bus turnaround costs dead cycles. To limit them, the arbiter keeps the current direction until a minimum number of bursts has been served in it. A read-to-write change needs a full write queue and a minimum run of reads, unless the read queue has emptied. A write-to-read change needs a minimum run of writes and a drained write queue, unless the write queue is empty. The write watermarks are percentages of the write buffer depth. These watermarks and both minimum run lengths are fixed at elaboration.

Top module: `rw_turn_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, the direction is read (`dir_write`=0), `turn_pulse` is 0, and both per-direction burst counts are zero.
- R2: In read mode with a non-empty read queue and no write stall, the arbiter moves to write mode only when write occupancy is strictly greater than the high mark, floor(WBUF_DEPTH*HI_PCT/100) (54 by default), and at least MIN_RD reads (16 by default) have been counted since the last turn. An occupancy equal to the high mark keeps read mode.
- R3: In read mode, if fewer than MIN_RD reads have been counted and the read queue is not empty, write occupancy above the high mark does not change the direction.
- R4: In read mode with an empty read queue, a non-zero write occupancy and no write stall, the arbiter moves to write mode at once, whatever the counts and the high mark.
- R5: While `wr_stall` is high, no read-to-write change takes place.
- R6: In write mode with a non-empty write queue, the arbiter returns to read mode only when at least MIN_WR writes (16 by default) have been counted and write occupancy is at or below the low mark, floor(WBUF_DEPTH*LO_PCT/100) (32 by default). Occupancy one above the low mark keeps write mode.
- R7: In write mode, an empty write queue returns the arbiter to read mode at once, whatever the count.
- R8: Both burst counts are cleared on every change of direction. An issue pulse in the cycle of the change is not carried into the new period. Issue pulses are counted in either direction.
- R9: The burst counts saturate at their maximum value (2^CW-1, with CW=$clog2(max(MIN_RD,MIN_WR)+1)) and do not wrap.
- R10: `dir_write` and `turn_pulse` are registered. They update on the clock edge that samples the deciding inputs. `turn_pulse` is high for exactly the one cycle after each change and low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_occ | input | $clog2(RBUF_DEPTH+1) | Read queue occupancy |
| wr_occ | input | $clog2(WBUF_DEPTH+1) | Write queue occupancy |
| rd_issue | input | 1 | One read burst issued this cycle |
| wr_issue | input | 1 | One write burst issued this cycle |
| wr_stall | input | 1 | Write path cannot accept another write |
| dir_write | output | 1 | 1 = bus serves writes, 0 = reads |
| turn_pulse | output | 1 | High for one cycle after a direction change |

## Verification
The bench drives write occupancy just at and just above each watermark, so an off-by-one comparison shows up. It drives burst runs one short of and exactly at each minimum, which separates a missing or misplaced count check from a correct one. It tests the empty-queue shortcuts, both with and without the write stall, to tell them apart from the watermark path. It issues long read runs and then checks that the turn still happens, which exposes a wrapping counter. It runs stale pulses across a turn and then checks that the turn is held back, which exposes a counter that is not cleared.

// File: rtl/rwt_pkg.sv
package rwt_pkg;
  typedef enum logic {
    BUS_RD = 1'b0,
    BUS_WR = 1'b1
  } bus_dir_e;
endpackage

// File: rtl/rwt_sat_counter.sv
module rwt_sat_counter #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '0;
    else if (clr)               cnt_q <= '0;
    else if (inc && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R8: a clear leaves zero on the next cycle
  assert_clr_zero_R8: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> cnt_q == '0);

  // R9: saturated count holds until cleared
  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_q) == TOP && !$past(clr)) |-> cnt_q == TOP);
endmodule

// File: rtl/rwt_watermark.sv
module rwt_watermark #(
  parameter int RW    = 7,
  parameter int WW    = 7,
  parameter int HI_TH = 54,
  parameter int LO_TH = 32
) (
  input  logic [RW-1:0] rd_occ,
  input  logic [WW-1:0] wr_occ,
  output logic          wr_above_hi,
  output logic          wr_at_lo,
  output logic          wr_empty,
  output logic          rd_empty
);
  localparam logic [WW-1:0] HI_V = WW'(HI_TH);
  localparam logic [WW-1:0] LO_V = WW'(LO_TH);

  always_comb begin
    wr_above_hi = wr_occ > HI_V;
    wr_at_lo    = wr_occ <= LO_V;
    wr_empty    = wr_occ == '0;
    rd_empty    = rd_occ == '0;
  end
endmodule

// File: rtl/rwt_dir_fsm.sv
module rwt_dir_fsm
  import rwt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_above_hi,
  input  logic wr_at_lo,
  input  logic wr_empty,
  input  logic rd_empty,
  input  logic rd_met,
  input  logic wr_met,
  input  logic wr_stall,
  output logic turn_now,
  output logic dir_write,
  output logic turn_pulse
);
  bus_dir_e dir_q;
  logic     pulse_q;
  logic     go_wr, go_rd;

  always_comb begin
    go_wr = (dir_q == BUS_RD) && !wr_stall &&
            ((wr_above_hi && (rd_met || rd_empty)) || (rd_empty && !wr_empty));
    go_rd = (dir_q == BUS_WR) && (wr_empty || (wr_met && wr_at_lo));
    turn_now = go_wr || go_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= BUS_RD;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= turn_now;
      if (go_wr)      dir_q <= BUS_WR;
      else if (go_rd) dir_q <= BUS_RD;
    end
  end

  assign dir_write  = (dir_q == BUS_WR);
  assign turn_pulse = pulse_q;

  // R10: pulse marks exactly the cycles following a change
  assert_pulse_on_turn_R10: assert property (@(posedge clk) disable iff (rst)
    pulse_q == (dir_q != $past(dir_q)));

  // R5: no read-to-write turn while the write path stalls
  assert_no_turn_stalled_R5: assert property (@(posedge clk) disable iff (rst)
    (dir_q == BUS_WR && $past(dir_q) == BUS_RD) |-> !$past(wr_stall));

  // R2/R3/R4: read-to-write turn only from a permitted condition
  assert_rd2wr_guard_R3: assert property (@(posedge clk) disable iff (rst)
    (dir_q == BUS_WR && $past(dir_q) == BUS_RD) |->
      $past((wr_above_hi && (rd_met || rd_empty)) || (rd_empty && !wr_empty)));

  // R6/R7: write-to-read turn only from a permitted condition
  assert_wr2rd_guard_R6: assert property (@(posedge clk) disable iff (rst)
    (dir_q == BUS_RD && $past(dir_q) == BUS_WR) |->
      $past(wr_empty || (wr_met && wr_at_lo)));
endmodule

// File: rtl/rw_turn_arbiter.sv
module rw_turn_arbiter #(
  parameter int WBUF_DEPTH = 64,
  parameter int RBUF_DEPTH = 64,
  parameter int HI_PCT     = 85,
  parameter int LO_PCT     = 50,
  parameter int MIN_RD     = 16,
  parameter int MIN_WR     = 16,
  localparam int RW = $clog2(RBUF_DEPTH + 1),
  localparam int WW = $clog2(WBUF_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] rd_occ,
  input  logic [WW-1:0] wr_occ,
  input  logic          rd_issue,
  input  logic          wr_issue,
  input  logic          wr_stall,
  output logic          dir_write,
  output logic          turn_pulse
);
  localparam int HI_TH   = (WBUF_DEPTH * HI_PCT) / 100;
  localparam int LO_TH   = (WBUF_DEPTH * LO_PCT) / 100;
  localparam int MAX_MIN = (MIN_RD > MIN_WR) ? MIN_RD : MIN_WR;
  localparam int CW      = $clog2(MAX_MIN + 1);
  localparam int NCNT    = 2;

  localparam logic [CW-1:0] MIN_V [NCNT] = '{CW'(MIN_RD), CW'(MIN_WR)};

  logic          wr_above_hi, wr_at_lo, wr_empty, rd_empty;
  logic          turn_now;
  logic [NCNT-1:0] issue_v;
  logic [NCNT-1:0] met_v;
  logic [CW-1:0] cnt_v [NCNT];

  assign issue_v = {wr_issue, rd_issue};

  rwt_watermark #(
    .RW(RW), .WW(WW), .HI_TH(HI_TH), .LO_TH(LO_TH)
  ) u_mark (
    .rd_occ(rd_occ), .wr_occ(wr_occ),
    .wr_above_hi(wr_above_hi), .wr_at_lo(wr_at_lo),
    .wr_empty(wr_empty), .rd_empty(rd_empty)
  );

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    rwt_sat_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst(rst), .clr(turn_now),
      .inc(issue_v[g]), .cnt(cnt_v[g])
    );
    assign met_v[g] = cnt_v[g] >= MIN_V[g];
  end

  rwt_dir_fsm u_fsm (
    .clk(clk), .rst(rst),
    .wr_above_hi(wr_above_hi), .wr_at_lo(wr_at_lo),
    .wr_empty(wr_empty), .rd_empty(rd_empty),
    .rd_met(met_v[0]), .wr_met(met_v[1]),
    .wr_stall(wr_stall), .turn_now(turn_now),
    .dir_write(dir_write), .turn_pulse(turn_pulse)
  );

  // R1: first cycle after reset is idle read mode with clear counts
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!dir_write && !turn_pulse && cnt_v[0] == '0 && cnt_v[1] == '0));
endmodule

// File: tb/sim_rw_turn_arbiter.sv
module sim_rw_turn_arbiter;
  localparam int RW = 7;
  localparam int WW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RW-1:0] rd_occ = '0;
  logic [WW-1:0] wr_occ = '0;
  logic rd_issue = 1'b0, wr_issue = 1'b0, wr_stall = 1'b0;
  logic dir_write, turn_pulse;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  rw_turn_arbiter u0 (
    .clk(clk), .rst(rst), .rd_occ(rd_occ), .wr_occ(wr_occ),
    .rd_issue(rd_issue), .wr_issue(wr_issue), .wr_stall(wr_stall),
    .dir_write(dir_write), .turn_pulse(turn_pulse)
  );

  // Expected marks from the requirements: high 54, low 32, minimums 16
  // row: cycles[28:21] rd[20:13] wr[12:5] rd_iss[4] wr_iss[3] stall[2] dir[1] pulse[0]
  localparam int NROW = 19;
  localparam logic [28:0] TBL [NROW] = '{
    {8'd1,  8'd10, 8'd54, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 equal to mark
    {8'd1,  8'd10, 8'd55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 count 0
    {8'd15, 8'd10, 8'd20, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // 15 reads
    {8'd1,  8'd10, 8'd55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 count 15
    {8'd1,  8'd10, 8'd20, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // 16th read
    {8'd1,  8'd10, 8'd55, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 stalled
    {8'd1,  8'd10, 8'd55, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R2 turn
    {8'd1,  8'd10, 8'd55, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R10 single pulse
    {8'd1,  8'd10, 8'd20, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 count 0
    {8'd16, 8'd10, 8'd40, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // 16 writes, above low
    {8'd1,  8'd10, 8'd33, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 low+1
    {8'd1,  8'd10, 8'd32, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 turn at low
    {8'd1,  8'd10, 8'd32, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R10 pulse drops
    {8'd1,  8'd10, 8'd60, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 reads cleared
    {8'd1,  8'd0,  8'd3,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R4 empty reads
    {8'd1,  8'd0,  8'd3,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 hold
    {8'd1,  8'd0,  8'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 empty writes
    {8'd1,  8'd0,  8'd5,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 stall on shortcut
    {8'd1,  8'd0,  8'd5,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1}  // R4 after stall lifts
  };

  task automatic run(input int n, input int rd, input int wr,
                     input logic ri, input logic wi, input logic st);
    for (int i = 0; i < n; i++) begin
      rd_occ = RW'(rd); wr_occ = WW'(wr);
      rd_issue = ri; wr_issue = wi; wr_stall = st;
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input logic exp_dir, input logic exp_pul);
    checks++;
    if (dir_write !== exp_dir) begin
      errors++;
      $display("FAIL %s dir_write actual=%b expected=%b", req, dir_write, exp_dir);
    end
    checks++;
    if (turn_pulse !== exp_pul) begin
      errors++;
      $display("FAIL %s turn_pulse actual=%b expected=%b", req, turn_pulse, exp_pul);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    run(3, 0, 0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 in reset", 1'b0, 1'b0);

    for (int r = 0; r < NROW; r++) begin
      run(int'(TBL[r][28:21]), int'(TBL[r][20:13]), int'(TBL[r][12:5]),
          TBL[r][4], TBL[r][3], TBL[r][2]);
      check($sformatf("R2-table row %0d", r), TBL[r][1], TBL[r][0]);
    end

    // R1: reset from write mode, counts cleared (16 reads first)
    run(16, 10, 20, 1'b1, 1'b0, 1'b0);
    rst = 1'b1;
    run(2, 10, 20, 1'b0, 1'b0, 1'b0);
    check("R1 reset from write", 1'b0, 1'b0);
    rst = 1'b0;
    run(1, 10, 60, 1'b0, 1'b0, 1'b0);
    check("R1 read count zero after reset", 1'b0, 1'b0);

    // R9: 40 reads saturate; a wrapped count would be 8
    do_reset();
    run(40, 10, 20, 1'b1, 1'b0, 1'b0);
    check("R9 long run no turn", 1'b0, 1'b0);
    run(1, 10, 55, 1'b0, 1'b0, 1'b0);
    check("R9 saturated count allows turn", 1'b1, 1'b1);

    // R8: writes counted in read mode are dropped at the turn
    do_reset();
    run(16, 10, 20, 1'b0, 1'b1, 1'b0);
    run(1, 0, 20, 1'b0, 1'b1, 1'b0);
    check("R8 shortcut turn", 1'b1, 1'b1);
    run(1, 10, 20, 1'b0, 1'b0, 1'b0);
    check("R8 write count cleared", 1'b1, 1'b0);
    run(15, 10, 20, 1'b0, 1'b1, 1'b0);
    run(1, 10, 20, 1'b0, 1'b0, 1'b0);
    check("R6 15 writes hold", 1'b1, 1'b0);
    run(1, 10, 20, 1'b0, 1'b1, 1'b0);
    run(1, 10, 20, 1'b0, 1'b0, 1'b0);
    check("R6 16 writes turn", 1'b0, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule